// File: doc/BRIEF.md
# Associative memory road finder

This block holds a bank of coarse track templates and checks them all at once against coarse hit addresses that arrive on one bus per detector layer. Every template keeps one stored word, one comparator and one sticky flag per layer. A flag is set the first time a hit on its layer equals the stored word, so matching happens while the event's hits stream in and no extra search pass is needed.

An end-of-event strobe closes the event. The block freezes the flags and builds a road list. A template counts a layer as satisfied in one of two cases: the layer is a normal layer and its flag is set, or the layer is a veto layer and its flag is clear. Don't-care layers are never counted. A template is a road when its satisfied count reaches a threshold given on a port. Road indices then leave one per clock in ascending order. A one-cycle end marker follows the last road, and the flags clear in that same cycle so that the next event starts clean.

The templates can be rewritten at any time through a write port. This lets the bank follow changes in detector alignment or beam position.

Top module: `am_road_finder`

## Requirements
- R1: After reset `road_vld` and `road_end` are low, and every template has an empty care mask. An event closed right after reset with `thresh`=0 therefore yields only the end marker.
- R2: A cycle with `wr_en` high replaces all the stored words of template `wr_addr`, together with its care and veto masks. Layer l's word is `wr_words[l*WORDW +: WORDW]`. Bit l of `wr_care` and bit l of `wr_veto` apply to layer l. Later hits are compared only against the new words.
- R3: A hit with `hit_vld[l]`=1 and `hit_ss[l*WORDW +: WORDW]` equal to a template's layer-l word sets that template's layer-l flag. Flags are sticky for the whole event, repeated hits change nothing, and all layers are examined in the same cycle.
- R4: A template is a road when its satisfied-layer count is at least `thresh`. With `thresh`=5, one missing layer out of six is tolerated.
- R5: A layer whose care bit and veto bit are both set counts as satisfied only when no matching hit arrived on that layer during the event.
- R6: A layer whose care bit is clear is never counted. A template whose care mask is all zero is never a road, even when `thresh`=0.
- R7: If the strobe is sampled at clock edge k, the roads appear at edges k+1 to k+N, one per cycle, in strictly ascending index order, with `road_vld` high on consecutive cycles.
- R8: `road_end` pulses for exactly one cycle, at edge k+N+1. It is never high together with `road_vld`.
- R9: All flags clear at the edge that raises `road_end`, so no hit from one event contributes to the next event.
- R10: While a readout is in progress, hits and end-of-event strobes are ignored.
- R11: Hits presented in the same cycle as the end-of-event strobe belong to the event that the strobe closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Template write enable |
| wr_addr | input | $clog2(NPAT) | Template index to write |
| wr_words | input | NLAYER*WORDW | Stored words, one per layer |
| wr_care | input | NLAYER | Per-layer care bits (0 = don't-care) |
| wr_veto | input | NLAYER | Per-layer veto bits (1 = layer must be absent) |
| hit_vld | input | NLAYER | Per-layer hit valid |
| hit_ss | input | NLAYER*WORDW | Per-layer coarse hit address |
| eoe | input | 1 | End-of-event strobe |
| thresh | input | $clog2(NLAYER+1) | Satisfied-layer count needed for a road |
| road_vld | output | 1 | Road index valid |
| road_id | output | $clog2(NPAT) | Road (template) index |
| road_end | output | 1 | End-of-event marker |

## Verification
With a strobe sampled at edge k, the first road is due just after edge k+1, the n-th road just after edge k+n, and the marker just after edge k+N+1. The bench drives every input at the falling edge. It then samples one nanosecond after each rising edge and walks the expected road set in ascending order, so every road is checked in exactly the cycle it is due, and a missing or extra road shows up at the position of the marker. Flag clearing and the ignoring of inputs during readout are checked through the road list of the event that follows.

// File: rtl/am_road_finder.sv
module am_road_finder #(
  parameter int NLAYER = 6,
  parameter int WORDW  = 12,
  parameter int NPAT   = 128,
  localparam int IDW   = $clog2(NPAT),
  localparam int CW    = $clog2(NLAYER + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDW-1:0]          wr_addr,
  input  logic [NLAYER*WORDW-1:0] wr_words,
  input  logic [NLAYER-1:0]       wr_care,
  input  logic [NLAYER-1:0]       wr_veto,
  input  logic [NLAYER-1:0]       hit_vld,
  input  logic [NLAYER*WORDW-1:0] hit_ss,
  input  logic                    eoe,
  input  logic [CW-1:0]           thresh,
  output logic                    road_vld,
  output logic [IDW-1:0]          road_id,
  output logic                    road_end
);

  logic [WORDW-1:0]  word_q [NPAT][NLAYER];
  logic [NLAYER-1:0] care_q [NPAT];
  logic [NLAYER-1:0] veto_q [NPAT];
  logic [NLAYER-1:0] flag_q [NPAT];
  logic [NLAYER-1:0] flag_d [NPAT];
  logic [NPAT-1:0]   road_d;
  logic [NPAT-1:0]   pend_q;
  logic              busy_q;
  logic [IDW-1:0]    pick;
  logic              any_pend;

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int l = 0; l < NLAYER; l++)
        word_q[wr_addr][l] <= wr_words[l*WORDW +: WORDW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAT; p++) begin
        care_q[p] <= '0;
        veto_q[p] <= '0;
      end
    end else if (wr_en) begin
      care_q[wr_addr] <= wr_care;
      veto_q[wr_addr] <= wr_veto;
    end
  end

  always_comb begin
    for (int p = 0; p < NPAT; p++) begin
      logic [NLAYER-1:0] sat;
      for (int l = 0; l < NLAYER; l++)
        flag_d[p][l] = flag_q[p][l] |
          (!busy_q && hit_vld[l] && (hit_ss[l*WORDW +: WORDW] == word_q[p][l]));
      sat = care_q[p] & (flag_d[p] ^ veto_q[p]);
      road_d[p] = (|care_q[p]) && (CW'($countones(sat)) >= thresh);
    end
  end

  always_comb begin
    pick = '0;
    for (int p = NPAT - 1; p >= 0; p--)
      if (pend_q[p]) pick = IDW'(p);
  end

  assign any_pend = |pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAT; p++) flag_q[p] <= '0;
      busy_q   <= 1'b0;
      pend_q   <= '0;
      road_vld <= 1'b0;
      road_id  <= '0;
      road_end <= 1'b0;
    end else begin
      road_vld <= 1'b0;
      road_end <= 1'b0;
      if (!busy_q) begin
        flag_q <= flag_d;
        if (eoe) begin
          busy_q <= 1'b1;
          pend_q <= road_d;
        end
      end else if (any_pend) begin
        road_vld     <= 1'b1;
        road_id      <= pick;
        pend_q[pick] <= 1'b0;
      end else begin
        road_end <= 1'b1;
        busy_q   <= 1'b0;
        for (int p = 0; p < NPAT; p++) flag_q[p] <= '0;
      end
    end
  end

endmodule

// File: rtl/am_road_finder_chk.sv
module am_road_finder_chk #(
  parameter int NPAT = 128,
  localparam int IDW = $clog2(NPAT)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           road_vld,
  input logic [IDW-1:0] road_id,
  input logic           road_end
);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(road_vld && road_end));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    road_end |=> (!road_end && !road_vld));

  p_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    road_vld |=> (road_vld || road_end));

  p_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (road_vld && $past(road_vld)) |-> (road_id > $past(road_id)));

endmodule

bind am_road_finder am_road_finder_chk #(.NPAT(NPAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .road_vld(road_vld), .road_id(road_id), .road_end(road_end)
);

// File: tb/tb_am_road_finder.sv
`timescale 1ns/1ps
module tb_am_road_finder;
  localparam int NL = 6, W = 12, NP = 128, IDW = $clog2(NP), CW = $clog2(NL + 1);

  typedef struct packed {
    logic [2:0]  thr;
    logic        eoe;
    logic [5:0]  vld;
    logic [23:0] tgt;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd5, 1'b1, 6'h3F, 24'h000000, 16'h0001},   // R3 R4 all six layers
    '{3'd5, 1'b0, 6'h07, 24'h000333, 16'h0000},   // R3 R9 spread over cycles
    '{3'd5, 1'b0, 6'h38, 24'h033000, 16'h0000},
    '{3'd5, 1'b1, 6'h00, 24'h000000, 16'h0008},
    '{3'd5, 1'b0, 6'h3F, 24'h011111, 16'h0000},   // R5 R7 two roads
    '{3'd5, 1'b1, 6'h3F, 24'h555555, 16'h0022},
    '{3'd6, 1'b1, 6'h3F, 24'h111111, 16'h0000},   // R5 veto layer present
    '{3'd6, 1'b1, 6'h1F, 24'h011111, 16'h0002},   // R5 veto layer absent
    '{3'd4, 1'b1, 6'h3F, 24'h222222, 16'h0004},   // R6 don't-care layers
    '{3'd5, 1'b1, 6'h3F, 24'h222222, 16'h0000},   // R6 not counted
    '{3'd5, 1'b0, 6'h03, 24'h000000, 16'h0000},   // R3 sticky, repeats
    '{3'd5, 1'b0, 6'h03, 24'h000000, 16'h0000},
    '{3'd5, 1'b1, 6'h2C, 24'h000000, 16'h0001},   // R4 R11 one missing layer
    '{3'd0, 1'b1, 6'h00, 24'h000000, 16'h002F}    // R6 R7 threshold zero
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [IDW-1:0] wr_addr = '0;
  logic [NL*W-1:0] wr_words = '0;
  logic [NL-1:0] wr_care = '0, wr_veto = '0, hit_vld = '0;
  logic [NL*W-1:0] hit_ss = '0;
  logic eoe = 0;
  logic [CW-1:0] thresh = '0;
  logic road_vld, road_end;
  logic [IDW-1:0] road_id;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  am_road_finder dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prog(input int p, input logic [7:0] base, input logic [5:0] care, input logic [5:0] veto);
    @(negedge clk);
    wr_en = 1; wr_addr = IDW'(p); wr_care = care; wr_veto = veto;
    for (int l = 0; l < NL; l++) wr_words[l*W +: W] = {base, 4'(l)};
    @(posedge clk);
    @(negedge clk) wr_en = 0;
  endtask

  task automatic drive(input logic [5:0] vld, input logic [23:0] tgt, input bit e, input logic [2:0] thr);
    @(negedge clk);
    hit_vld = vld; eoe = e; thresh = thr;
    for (int l = 0; l < NL; l++) hit_ss[l*W +: W] = {4'h0, tgt[l*4 +: 4], 4'(l)};
    @(posedge clk);
  endtask

  task automatic readout(input logic [15:0] exp, input bit junk, input string req);
    for (int i = 0; i < 16; i++) begin
      if (exp[i]) begin
        @(negedge clk);
        hit_vld = junk ? 6'h3F : 6'h00; eoe = junk;
        for (int l = 0; l < NL; l++) hit_ss[l*W +: W] = {8'h00, 4'(l)};
        @(posedge clk); #1;
        chk(road_vld && !road_end && road_id == IDW'(i), req, {road_vld, road_end, 8'(road_id)}, {2'b10, 8'(i)});
      end
    end
    @(negedge clk);
    hit_vld = junk ? 6'h3F : 6'h00; eoe = junk;
    @(posedge clk); #1;
    chk(road_end && !road_vld, {req, " R8"}, {road_vld, road_end}, 2'b01);
    @(negedge clk); hit_vld = '0; eoe = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk(!road_vld && !road_end, "R1", {road_vld, road_end}, 0);
    @(negedge clk) rst_n = 1;
    drive(6'h00, 24'h0, 1'b1, 3'd0);              // R1 empty care masks
    readout(16'h0000, 1'b0, "R1");

    prog(0, 8'h00, 6'h3F, 6'h00);                 // R2 program bank
    prog(1, 8'h01, 6'h3F, 6'h20);
    prog(2, 8'h02, 6'h0F, 6'h00);
    prog(3, 8'h03, 6'h3F, 6'h00);
    prog(5, 8'h05, 6'h3F, 6'h00);
    prog(9, 8'h09, 6'h00, 6'h00);

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].vld, TBL[v].tgt, TBL[v].eoe, TBL[v].thr);
      if (TBL[v].eoe) readout(TBL[v].exp, 1'b0, "R7 R4 R5 R6 R3");
    end

    drive(6'h00, 24'h0, 1'b1, 3'd0);              // R10 junk during readout
    readout(16'h002F, 1'b1, "R10");
    drive(6'h00, 24'h0, 1'b1, 3'd5);              // R10 R9 junk left no flags
    readout(16'h0000, 1'b0, "R10 R9");

    prog(0, 8'hA0, 6'h3F, 6'h00);                 // R2 rewrite
    drive(6'h3F, 24'h000000, 1'b1, 3'd5);
    readout(16'h0000, 1'b0, "R2 old words");
    @(negedge clk);
    hit_vld = 6'h3F; eoe = 1; thresh = 3'd6;
    for (int l = 0; l < NL; l++) hit_ss[l*W +: W] = {8'hA0, 4'(l)};
    @(posedge clk);
    readout(16'h0001, 1'b0, "R2 new words");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule